// File: doc/BRIEF.md
# Memory Bus Cycle Sequencer

This block turns single-cycle requests from a processor core into the external timing of an 8-bit processor's memory machine cycles. Three cycle shapes share one sequencer: an opcode fetch of four T-states, and a memory read or a memory write of three T-states each. A T-state is one clock period. The state advances on rising clock edges. A falling-edge register stage places control transitions half a clock away from the state changes.

The core presents a request: a kind, a 16-bit address, a flag that takes the address from the program counter, and a write byte. The sequencer drives the 16-bit address bus, a tri-state data driver (value plus enable) and the active-low strobes for fetch marker, memory request, read, write and refresh. It stretches a cycle while the wait input is low. It returns the captured byte with a one-clock completion pulse. It owns the program counter and a 7-bit refresh counter. A new request is accepted in the final T-state of the running cycle, so cycles run back to back with no idle clock between them.

Top module: `bus_cycle_seq`

## Requirements
- R1: A fetch (req_kind 0) lasts T1..T4 with no wait, and m1_n is low through T1, T2 and any wait state. The address bus carries the program counter during those states, and the counter is incremented once when the fetch is accepted.
- R2: In fetch and read cycles, mreq_n and rd_n fall together at the falling edge in T1.
- R3: In a fetch, the data byte is captured at the rising edge that begins T3, and mreq_n and rd_n rise at that same edge.
- R4: In fetch T3 and T4, rfsh_n is low and the address bus is {9 zero bits, 7-bit refresh count}. mreq_n is low from the falling edge of T3 to the falling edge of T4. The count starts at 0, advances by one per fetch and wraps from 127 to 0.
- R5: wait_n is sampled at the falling edge of T2 and of each wait state. Each low sample inserts one full wait clock, during which all strobes hold their levels.
- R6: A read (req_kind 1 or 3) lasts three T-states with m1_n high. Data is captured at the falling edge of T3, where mreq_n and rd_n rise. With req_use_pc set, a read takes its address from the program counter and increments it; otherwise it uses req_addr.
- R7: A write (req_kind 2) drives data_oe with req_wdata on data_o and lowers mreq_n at the falling edge of T1. It lowers wr_n one clock later, at the falling edge of T2. Both strobes rise at the falling edge of T3, and data_oe drops at the end of T3.
- R8: rd_n and wr_n are never low at the same time.
- R9: req_ready is high only when idle or in a cycle's final T-state. A request raised at any other time has no effect. A request accepted in the final T-state starts T1 on the next clock.
- R10: During and after reset, all strobes are high, data_oe is low, req_ready is high, done is low and pc is PC_RESET (0).
- R11: done is high for exactly the one clock after a cycle's final T-state. For fetches and reads, rdata then holds the captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one period is one T-state |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core presents a request |
| req_kind | input | 2 | 0 fetch, 1 or 3 read, 2 write |
| req_addr | input | 16 | Address for read or write without program-counter use |
| req_use_pc | input | 1 | Read takes its address from the program counter |
| req_wdata | input | 8 | Byte to store on a write |
| req_ready | output | 1 | Sequencer can accept a request at the next rising edge |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte captured by the last fetch or read |
| pc | output | 16 | Program counter |
| addr_bus | output | 16 | External address bus |
| data_o | output | 8 | Value for the tri-state data driver |
| data_oe | output | 1 | Data driver enable |
| data_i | input | 8 | Data bus as seen from outside |
| wait_n | input | 1 | Active-low stretch request from memory |
| m1_n | output | 1 | Active-low opcode fetch marker |
| mreq_n | output | 1 | Active-low memory request |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| rfsh_n | output | 1 | Active-low refresh marker |

## Verification
The bench samples every output in the middle of each half clock and compares it with a per-half-T-state expectation. This places each strobe edge on the right edge polarity and in the right T-state. Runs of fetches wrap the refresh count and separate correct counter handling from an off-by-one or missing wrap. Random mixes of kinds, wait counts of zero to three, program-counter reads and idle gaps separate back-to-back acceptance from idle insertion and show that a wait stretches each shape by exactly one clock per low sample. Requests raised mid-cycle show whether the busy sequencer ignores them.

// File: rtl/bus_seq_pkg.sv
// Shared types for the memory bus cycle sequencer.
// Assumes: one T-state equals one clock period.
package bus_seq_pkg;
    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_TW   = 3'd3,
        TS_T3   = 3'd4,
        TS_T4   = 3'd5
    } tstate_e;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    // Kind code 3 is handled as a read.
    function automatic cyc_e decode_kind(input logic [1:0] code);
        case (code)
            2'd0:    return CYC_FETCH;
            2'd2:    return CYC_WRITE;
            default: return CYC_READ;
        endcase
    endfunction
endpackage

// File: rtl/bus_tstate_ctrl.sv
// T-state sequencer: rising-edge state register for the cycle shapes.
// Assumes: wait_low is sampled on the falling edge of T2/TW by the edge stage.
module bus_tstate_ctrl
    import bus_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic [1:0] req_kind,
    input  logic    wait_low,
    output tstate_e tstate,
    output cyc_e    kind,
    output logic    accept,
    output logic    ready,
    output logic    to_t3,
    output logic    done
);
    logic last;

    // Final T-state detection and request acceptance
    always_comb begin
        last   = ((tstate == TS_T3) && (kind != CYC_FETCH)) || (tstate == TS_T4);
        ready  = (tstate == TS_IDLE) || last;
        accept = req_valid && ready;
        to_t3  = ((tstate == TS_T2) || (tstate == TS_TW)) && !wait_low;
    end

    // State, cycle kind and completion pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tstate <= TS_IDLE;
            kind   <= CYC_FETCH;
            done   <= 1'b0;
        end else begin
            done <= last;
            if (accept) begin
                tstate <= TS_T1;
                kind   <= decode_kind(req_kind);
            end else begin
                case (tstate)
                    TS_T1:          tstate <= TS_T2;
                    TS_T2, TS_TW:   tstate <= wait_low ? TS_TW : TS_T3;
                    TS_T3:          tstate <= (kind == CYC_FETCH) ? TS_T4 : TS_IDLE;
                    TS_T4:          tstate <= TS_IDLE;
                    default:        tstate <= TS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/bus_edge_stage.sv
// Falling-edge register stage: gives strobes their half-T-state offsets,
// samples wait_n and captures read data in T3.
// Assumes: tstate/kind are stable around the falling edge.
module bus_edge_stage
    import bus_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tstate_e       tstate,
    input  cyc_e          kind,
    input  logic          wait_n,
    input  logic [DW-1:0] data_i,
    output logic          acc_q,
    output logic          rf_q,
    output logic          wr_q,
    output logic          oe_q,
    output logic          wait_low_q,
    output logic [DW-1:0] cap_q
);
    logic early;

    // Access window: from falling edge of T1 through the waits
    always_comb early = (tstate == TS_T1) || (tstate == TS_T2) || (tstate == TS_TW);

    // Half-clock-offset strobe and sample registers
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            acc_q      <= 1'b0;
            rf_q       <= 1'b0;
            wr_q       <= 1'b0;
            oe_q       <= 1'b0;
            wait_low_q <= 1'b0;
            cap_q      <= '0;
        end else begin
            acc_q      <= early;
            rf_q       <= (kind == CYC_FETCH) && (tstate == TS_T3);
            wr_q       <= (kind == CYC_WRITE) && ((tstate == TS_T2) || (tstate == TS_TW));
            oe_q       <= (kind == CYC_WRITE) && early;
            wait_low_q <= ((tstate == TS_T2) || (tstate == TS_TW)) && !wait_n;
            if ((tstate == TS_T3) && (kind == CYC_READ))
                cap_q <= data_i;
        end
    end
endmodule

// File: rtl/bus_addr_path.sv
// Address path: program counter, refresh counter, address latch,
// write data latch and returned byte.
// Assumes: accept is only high when the sequencer can start T1.
module bus_addr_path
    import bus_seq_pkg::*;
#(
    parameter int           AW       = 16,
    parameter int           DW       = 8,
    parameter int           RW       = 7,
    parameter logic [AW-1:0] PC_RESET = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic          req_use_pc,
    input  logic [DW-1:0] req_wdata,
    input  tstate_e       tstate,
    input  cyc_e          kind,
    input  logic          to_t3,
    input  logic [DW-1:0] data_i,
    input  logic [DW-1:0] cap_q,
    output logic [AW-1:0] addr_bus,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata
);
    localparam int PADW = AW - RW;

    logic [AW-1:0] addr_q;
    logic [RW-1:0] rcnt;
    logic          uses_pc;
    logic          rf_win;

    // Program-stream request and refresh window decode
    always_comb begin
        uses_pc = (decode_kind(req_kind) == CYC_FETCH) ||
                  ((decode_kind(req_kind) == CYC_READ) && req_use_pc);
        rf_win  = (kind == CYC_FETCH) && ((tstate == TS_T3) || (tstate == TS_T4));
        addr_bus = rf_win ? {{PADW{1'b0}}, rcnt} : addr_q;
    end

    // Address latch, program counter and write data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            pc      <= PC_RESET;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= uses_pc ? pc : req_addr;
            wdata_q <= req_wdata;
            if (uses_pc)
                pc <= pc + 1'b1;
        end
    end

    // Refresh counter advances as each fetch leaves T4
    always_ff @(posedge clk) begin
        if (!rst_n)
            rcnt <= '0;
        else if (tstate == TS_T4)
            rcnt <= rcnt + 1'b1;
    end

    // Returned byte: fetch at the rise into T3, read from the T3 capture
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if ((kind == CYC_FETCH) && to_t3)
            rdata <= data_i;
        else if ((kind == CYC_READ) && (tstate == TS_T3))
            rdata <= cap_q;
    end
endmodule

// File: rtl/bus_cycle_seq.sv
// Memory bus cycle sequencer top: joins the rising-edge state, the
// falling-edge strobe stage and the address path into bus pins.
// Assumes: a single clock; the data bus driver sits outside, using data_oe.
module bus_cycle_seq
    import bus_seq_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            DW       = 8,
    parameter int            RW       = 7,
    parameter logic [AW-1:0] PC_RESET = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic          req_use_pc,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] addr_bus,
    output logic [DW-1:0] data_o,
    output logic          data_oe,
    input  logic [DW-1:0] data_i,
    input  logic          wait_n,
    output logic          m1_n,
    output logic          mreq_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          rfsh_n
);
    tstate_e       tstate;
    cyc_e          kind;
    logic          accept, to_t3;
    logic          acc_q, rf_q, wr_q, oe_q, wait_low_q;
    logic [DW-1:0] cap_q, wdata_q;
    logic          mem_act, late;

    bus_tstate_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .wait_low(wait_low_q), .tstate(tstate), .kind(kind), .accept(accept),
        .ready(req_ready), .to_t3(to_t3), .done(done)
    );

    bus_edge_stage #(.DW(DW)) u_edge (
        .clk(clk), .rst_n(rst_n), .tstate(tstate), .kind(kind), .wait_n(wait_n),
        .data_i(data_i), .acc_q(acc_q), .rf_q(rf_q), .wr_q(wr_q), .oe_q(oe_q),
        .wait_low_q(wait_low_q), .cap_q(cap_q)
    );

    bus_addr_path #(.AW(AW), .DW(DW), .RW(RW), .PC_RESET(PC_RESET)) u_addr (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_kind(req_kind),
        .req_addr(req_addr), .req_use_pc(req_use_pc), .req_wdata(req_wdata),
        .tstate(tstate), .kind(kind), .to_t3(to_t3), .data_i(data_i),
        .cap_q(cap_q), .addr_bus(addr_bus), .pc(pc), .wdata_q(wdata_q),
        .rdata(rdata)
    );

    // Strobe assembly: fetch access ends at the rise into T3
    always_comb begin
        late    = (tstate == TS_T3) || (tstate == TS_T4);
        mem_act = acc_q && !((kind == CYC_FETCH) && late);
        mreq_n  = !(mem_act || rf_q);
        rd_n    = !(mem_act && (kind != CYC_WRITE));
        wr_n    = !wr_q;
        m1_n    = !((kind == CYC_FETCH) &&
                    ((tstate == TS_T1) || (tstate == TS_T2) || (tstate == TS_TW)));
        rfsh_n  = !((kind == CYC_FETCH) && late);
        data_oe = oe_q || ((kind == CYC_WRITE) && (tstate == TS_T3));
        data_o  = wdata_q;
    end
endmodule

// File: rtl/bus_cycle_seq_chk.sv
// Protocol checker for the bus cycle sequencer, bound to the top module.
// Assumes: sampling at both clock edges sees settled strobe levels.
module bus_cycle_seq_chk #(
    parameter int AW = 16,
    parameter int RW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          m1_n,
    input logic          mreq_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic          rfsh_n,
    input logic          data_oe,
    input logic          done,
    input logic [AW-1:0] addr_bus
);
    // R8
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
    // R8
    rd_wr_excl_neg_chk: assert property (@(negedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
    // R7
    wr_needs_mreq_chk: assert property (@(negedge clk) disable iff (!rst_n) !wr_n |-> !mreq_n);
    // R4
    rfsh_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_n |-> (addr_bus[AW-1:RW] == '0));
    // R4
    rfsh_no_m1_chk: assert property (@(negedge clk) disable iff (!rst_n) !rfsh_n |-> (m1_n && rd_n));
    // R7
    oe_no_rd_chk: assert property (@(negedge clk) disable iff (!rst_n) data_oe |-> rd_n);
    // R1
    m1_no_wr_chk: assert property (@(negedge clk) disable iff (!rst_n) !m1_n |-> wr_n);
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.AW(AW), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .mreq_n(mreq_n), .rd_n(rd_n),
    .wr_n(wr_n), .rfsh_n(rfsh_n), .data_oe(data_oe), .done(done),
    .addr_bus(addr_bus)
);

// File: tb/test_bus_cycle_seq.sv
// Self-checking bench: drives cycles, models memory with wait states and
// checks every output at mid-point of each half clock.
module test_bus_cycle_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_addr = 16'h0;
    logic        req_use_pc = 1'b0;
    logic [7:0]  req_wdata = 8'h0;
    logic        req_ready, done;
    logic [7:0]  rdata, data_o, data_i;
    logic [15:0] pc, addr_bus;
    logic        data_oe;
    logic        wait_n = 1'b1;
    logic        m1_n, mreq_n, rd_n, wr_n, rfsh_n;

    int          n_tests = 0;
    int          n_fail = 0;
    logic [15:0] pcm = 16'h0;
    logic [6:0]  rcm = 7'h0;
    logic        pend_done = 1'b0;
    logic        pend_has_data = 1'b0;
    logic [7:0]  pend_data = 8'h0;

    always #4 clk = ~clk;

    bus_cycle_seq i_bus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_use_pc(req_use_pc), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata), .pc(pc),
        .addr_bus(addr_bus), .data_o(data_o), .data_oe(data_oe), .data_i(data_i),
        .wait_n(wait_n), .m1_n(m1_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
        .rfsh_n(rfsh_n)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
    endfunction

    // Memory model: answers whenever the read strobe is low
    assign data_i = !rd_n ? memf(addr_bus) : 8'h00;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] exp_strobes(input int kind, input int st, input bit h);
        logic m1, mq, rd, wr, rf, oe, acc;
        acc = (st == 1 && h) || st == 2 || st == 3;
        m1 = 0; mq = 0; rd = 0; wr = 0; rf = 0; oe = 0;
        if (kind == 0) begin
            m1 = (st <= 3);
            mq = acc || (st == 4 && h) || (st == 5 && !h);
            rd = acc;
            rf = (st >= 4);
        end else if (kind == 2) begin
            mq = acc || (st == 4 && !h);
            wr = (st == 2 && h) || st == 3 || (st == 4 && !h);
            oe = acc || st == 4;
        end else begin
            mq = acc || (st == 4 && !h);
            rd = mq;
        end
        return {m1, mq, rd, wr, rf, oe};
    endfunction

    function automatic logic [5:0] act_strobes();
        return {!m1_n, !mreq_n, !rd_n, !wr_n, !rfsh_n, data_oe};
    endfunction

    // Idle clock: checks done pulse and quiet bus
    task automatic idle_clk();
        @(posedge clk); #2;
        chk(done == pend_done, "R11 done after cycle", done, pend_done);
        if (pend_done && pend_has_data)
            chk(rdata == pend_data, "R11 rdata", rdata, pend_data);
        chk(act_strobes() == 6'b0, "R9 idle strobes", act_strobes(), 0);
        chk(req_ready, "R9 ready idle", req_ready, 1);
        pend_done = 0;
        @(negedge clk); #2;
    endtask

    // One machine cycle; called in the second half of the preceding clock
    task automatic run_cycle(input int kind, input logic [15:0] a, input bit use_pc,
                             input logic [7:0] wd, input int nwait, input bit poke);
        bit          up;
        logic [15:0] ea;
        int          total;
        int          st;
        string       tg;
        up = (kind == 0) || (kind != 2 && use_pc);
        req_valid = 1; req_kind = kind[1:0]; req_addr = a; req_use_pc = use_pc; req_wdata = wd;
        chk(req_ready, "R9 ready before accept", req_ready, 1);
        ea = up ? pcm : a;
        if (up) pcm = pcm + 1;
        total = ((kind == 0) ? 4 : 3) + nwait;
        tg = (kind == 0) ? "R1 R3 fetch" : (kind == 2) ? "R7 write" : "R2 R6 read";
        for (int i = 0; i < total; i++) begin
            st = (i == 0) ? 1 : (i == 1) ? 2 : (i <= 1 + nwait) ? 3 : (i == 2 + nwait) ? 4 : 5;
            @(posedge clk); #1;
            req_valid = 0;
            if (st == 2) wait_n = (nwait > 0) ? 1'b0 : 1'b1;
            else if (st == 3) wait_n = (i - 1 < nwait) ? 1'b0 : 1'b1;
            else wait_n = 1'b1;
            if (poke && st == 2) begin req_valid = 1; req_kind = 2'd2; end
            #1;
            if (st == 1) begin
                chk(done == pend_done, "R11 done pulse", done, pend_done);
                if (pend_done && pend_has_data)
                    chk(rdata == pend_data, "R11 rdata", rdata, pend_data);
                pend_done = 0;
                chk(pc == pcm, "R1 R6 program counter", pc, pcm);
            end else begin
                chk(!done, "R11 done low mid-cycle", done, 0);
            end
            for (int h = 0; h < 2; h++) begin
                if (h == 1) begin
                    @(negedge clk); #1;
                    if (poke && st == 2) req_valid = 0;
                    #1;
                end
                chk(act_strobes() == exp_strobes(kind, st, h[0]),
                    (st == 3) ? "R5 wait-state strobes" : tg, act_strobes(), exp_strobes(kind, st, h[0]));
                chk(!(!rd_n && !wr_n), "R8 rd/wr exclusive", {rd_n, wr_n}, 2'b11);
                if (kind == 0 && st >= 4)
                    chk(addr_bus == {9'b0, rcm}, "R4 refresh address", addr_bus, {9'b0, rcm});
                else
                    chk(addr_bus == ea, (kind == 0) ? "R1 address" : "R6 R7 address", addr_bus, ea);
                chk(req_ready == ((st == 4 && kind != 0) || st == 5), "R9 ready",
                    req_ready, ((st == 4 && kind != 0) || st == 5));
                if (data_oe)
                    chk(data_o == wd, "R7 write data", data_o, wd);
            end
        end
        if (kind == 0) rcm = rcm + 1;
        pend_done = 1;
        pend_has_data = (kind != 2);
        pend_data = memf(ea);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int seed;
        int k, nw, gap;
        seed = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        // R10 reset state while held
        chk(act_strobes() == 6'b0 && m1_n && rfsh_n, "R10 strobes in reset", act_strobes(), 0);
        chk(pc == 16'h0, "R10 pc in reset", pc, 0);
        chk(!done && req_ready, "R10 done/ready in reset", {done, req_ready}, 2'b01);
        rst_n = 1;
        idle_clk();
        chk(pc == 16'h0 && act_strobes() == 6'b0, "R10 after reset", pc, 0);
        // Directed: fetch, read, write with no waits
        run_cycle(0, 16'h0, 0, 8'h00, 0, 0);
        run_cycle(1, 16'h2001, 0, 8'h00, 0, 0);
        run_cycle(2, 16'h2350, 0, 8'h9F, 0, 0);
        idle_clk();
        // Directed: waits on each shape, mid-cycle poke, program-stream read
        run_cycle(0, 16'h0, 0, 8'h00, 2, 1);
        run_cycle(1, 16'h0, 1, 8'h00, 1, 1);
        run_cycle(3, 16'hFFFF, 0, 8'h00, 3, 0);
        run_cycle(2, 16'h8000, 0, 8'h5A, 3, 1);
        idle_clk();
        // R4 refresh wrap: back-to-back fetches past 127
        for (int i = 0; i < 130; i++) run_cycle(0, 16'h0, 0, 8'h00, 0, 0);
        idle_clk();
        // Random mix
        for (int i = 0; i < 300; i++) begin
            k   = $urandom % 4;
            nw  = $urandom % 4;
            gap = $urandom % 3;
            run_cycle(k, 16'($urandom), 1'($urandom), 8'($urandom), (nw == 3) ? 0 : nw, 1'($urandom));
            if (gap == 0) idle_clk();
        end
        idle_clk();
        idle_clk();
        finish_run();
    end
endmodule